// File: doc/BRIEF.md
# Bidirectional DES Round-Key Generator

This block produces the sixteen 48-bit round keys of DES from a key that has already been reduced to its two 28-bit halves. A start pulse captures both halves and a mode bit. After that, each round-advance strobe moves the block to the next round by rotating both halves by the schedule amount. The Permuted Choice 2 selection of the current halves is presented at all times as the round key, together with the current round number.

The selection taps read the key for the last encryption round when the halves are not rotated. Encryption therefore applies a one-place left rotation as the halves are captured, and later rounds rotate left. Decryption uses the captured halves unchanged for its first round and then rotates them right, walking the schedule backwards. A finished flag rises once the strobe arrives in round 16. The key then holds until the next start.

Top module: `des_key_sched`

## Requirements
- R1: While reset is held and after its release, round_num is 0, done is 0 and round_key is zero, until the first start.
- R2: A start with enc_mode=1 captures both halves rotated left by one place. In the next cycle round_num is 1, done is 0 and round_key is the selection of those rotated halves.
- R3: A start with enc_mode=0 captures both halves unrotated. In the next cycle round_num is 1 and round_key is the selection of the halves exactly as loaded.
- R4: In encrypt mode, an advance strobe in round r (1 to 15) takes round_num to r+1 and rotates both halves left by S[r+1]. S[1..16] = 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1. Round r's key is therefore the selection of the halves rotated left by S[1]+...+S[r].
- R5: In decrypt mode, an advance strobe in round r (1 to 15) takes round_num to r+1 and rotates both halves right by S[17-r]. Round r's key therefore equals the encrypt-mode key for round 17-r.
- R6: Permuted Choice 2 forms round_key[47:24] from the C half only and round_key[23:0] from the D half only. Key bit k (1-based, with bit 1 = round_key[47]) takes bit PC2[k] of the 56-bit word {C,D}, whose bit 1 is C[27]. This is the standard 48-entry selection table.
- R7: An advance strobe in round 16 sets done. round_num stays 16 and round_key does not change. Further strobes have no effect until the next start.
- R8: An advance strobe before any start is ignored, and round_num stays 0.
- R9: start takes priority over an advance strobe in the same cycle. A start during a run restarts at round 1 with the new halves and mode.
- R10: enc_mode is sampled only at start. Changing it during a run changes neither the key nor the round. Cycles without a strobe leave the key and round unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture halves and mode, go to round 1 |
| enc_mode | input | 1 | 1 = encrypt, 0 = decrypt; sampled with start |
| c_load | input | 28 | C half after Permuted Choice 1 |
| d_load | input | 28 | D half after Permuted Choice 1 |
| adv | input | 1 | Round-advance strobe |
| round_key | output | 48 | Permuted Choice 2 key of the current round |
| round_num | output | 5 | Current round, 0 before the first start |
| done | output | 1 | Set after the strobe in round 16 |

## Verification
Start and the advance strobe can arrive in the same cycle. In that case the load and its pre-shift must win over the rotation the strobe would apply. The bench provokes this both in the middle of a run and just after done. It judges the result by requiring round 1 and the round-1 key computed by the bench for the new halves and mode. Randomly placed idle cycles, with enc_mode toggled during them, are interleaved with the strobes so that the hold behaviour is tested against the rotation.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;

   // Permuted Choice 2: entry k names the 1-based bit of {C,D} for key bit k+1
   localparam int PC2_TAB [48] = '{
      14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
      23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
      41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
      44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
   };

   // rotation applied on entering round r (1-based)
   function automatic logic [1:0] sched_amt(input int r);
      case (r)
         1, 2, 9, 16: sched_amt = 2'd1;
         default:     sched_amt = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/des_ks_rotor.sv
module des_ks_rotor #(
   parameter int W     = 28,
   parameter int MAXSH = 2,
   localparam int AW   = $clog2(MAXSH + 1)
) (
   input  logic [W-1:0]  x,
   input  logic [AW-1:0] amt,
   input  logic          left,
   output logic [W-1:0]  y
);
   logic [W-1:0] lrot [MAXSH+1];
   logic [W-1:0] rrot [MAXSH+1];

   if (MAXSH < 1 || MAXSH >= W) begin : g_bad_sh
      $error("des_ks_rotor: MAXSH out of range");
   end

   for (genvar k = 0; k <= MAXSH; k++) begin : g_amt
      if (k == 0) begin : g_zero
         assign lrot[k] = x;
         assign rrot[k] = x;
      end else begin : g_nz
         assign lrot[k] = {x[W-1-k:0], x[W-1:W-k]};
         assign rrot[k] = {x[k-1:0], x[W-1:k]};
      end
   end

   always_comb begin
      y = x;
      for (int k = 0; k <= MAXSH; k++) begin
         if (amt == AW'(k)) y = left ? lrot[k] : rrot[k];
      end
   end
endmodule

// File: rtl/des_ks_pc2.sv
module des_ks_pc2 #(
   parameter int HALF_W = 28,
   parameter int KEY_W  = 48
) (
   input  logic [HALF_W-1:0] c_half,
   input  logic [HALF_W-1:0] d_half,
   output logic [KEY_W-1:0]  key
);
   import des_ks_pkg::*;
   localparam int CD_W = 2 * HALF_W;
   logic [CD_W-1:0] cd;

   if (HALF_W != 28 || KEY_W != 48) begin : g_bad_w
      $error("des_ks_pc2: selection table fixes HALF_W=28 and KEY_W=48");
   end

   assign cd = {c_half, d_half};

   for (genvar k = 0; k < KEY_W; k++) begin : g_tap
      assign key[KEY_W-1-k] = cd[CD_W - PC2_TAB[k]];
   end
endmodule

// File: rtl/des_ks_round_ctr.sv
module des_ks_round_ctr #(
   parameter int ROUNDS = 16,
   parameter int MAXSH  = 2,
   localparam int RW    = $clog2(ROUNDS + 1),
   localparam int AW    = $clog2(MAXSH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          enc_in,
   input  logic          adv,
   output logic [RW-1:0] round,
   output logic          done,
   output logic          mode_q,
   output logic          upd,
   output logic [AW-1:0] rot_amt,
   output logic          rot_left
);
   import des_ks_pkg::*;

   logic active, step, finish;

   if (ROUNDS != 16) begin : g_bad_rounds
      $error("des_ks_round_ctr: the shift schedule covers 16 rounds");
   end

   assign active = (round != '0) && !done;
   assign step   = adv && !start && active && (round < RW'(ROUNDS));
   assign finish = adv && !start && active && (round == RW'(ROUNDS));
   assign upd    = start || step;

   always_comb begin
      rot_left = start ? 1'b1 : mode_q;
      if (start)
         rot_amt = enc_in ? AW'(1) : AW'(0);
      else if (step)
         rot_amt = mode_q ? AW'(sched_amt(int'(round) + 1))
                          : AW'(sched_amt(ROUNDS + 1 - int'(round)));
      else
         rot_amt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         round  <= '0;
         done   <= 1'b0;
         mode_q <= 1'b0;
      end else if (start) begin
         round  <= RW'(1);
         done   <= 1'b0;
         mode_q <= enc_in;
      end else if (step) begin
         round  <= round + RW'(1);
      end else if (finish) begin
         done   <= 1'b1;
      end
   end

   // R4
   step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (round == RW'($past(round) + RW'(1))));
   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(round)));
   // R8
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((round == '0) && !start) |=> (round == '0));
   // R9
   start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ((round == RW'(1)) && !done));
   // R10
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(mode_q));
endmodule

// File: rtl/des_key_sched.sv
module des_key_sched #(
   parameter int HALF_W = 28,
   parameter int KEY_W  = 48,
   parameter int ROUNDS = 16,
   localparam int RW    = $clog2(ROUNDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              enc_mode,
   input  logic [HALF_W-1:0] c_load,
   input  logic [HALF_W-1:0] d_load,
   input  logic              adv,
   output logic [KEY_W-1:0]  round_key,
   output logic [RW-1:0]     round_num,
   output logic              done
);
   localparam int MAXSH = 2;
   localparam int AW    = $clog2(MAXSH + 1);

   logic          mode_q, upd, rot_left;
   logic [AW-1:0] rot_amt;
   logic [HALF_W-1:0] half_q   [2];
   logic [HALF_W-1:0] half_src [2];
   logic [HALF_W-1:0] half_nxt [2];
   logic [HALF_W-1:0] loads    [2];

   assign loads[0] = c_load;
   assign loads[1] = d_load;

   des_ks_round_ctr #(.ROUNDS(ROUNDS), .MAXSH(MAXSH)) ctr_i (
      .clk(clk), .rst_n(rst_n), .start(start), .enc_in(enc_mode), .adv(adv),
      .round(round_num), .done(done), .mode_q(mode_q), .upd(upd),
      .rot_amt(rot_amt), .rot_left(rot_left)
   );

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign half_src[h] = start ? loads[h] : half_q[h];

      des_ks_rotor #(.W(HALF_W), .MAXSH(MAXSH)) rot_i (
         .x(half_src[h]), .amt(rot_amt), .left(rot_left), .y(half_nxt[h])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   half_q[h] <= '0;
         else if (upd) half_q[h] <= half_nxt[h];
      end
   end

   des_ks_pc2 #(.HALF_W(HALF_W), .KEY_W(KEY_W)) pc2_i (
      .c_half(half_q[0]), .d_half(half_q[1]), .key(round_key)
   );

   // R7
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(round_key));
   // R10
   idle_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !adv) |=> $stable(round_key));
   // R1
   reset_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (round_num == '0) |-> (round_key == '0));
   // R2 R3
   mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (mode_q == $past(enc_mode)));
endmodule

// File: tb/des_key_sched_tb_top.sv
module des_key_sched_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, enc_mode = 1'b0, adv = 1'b0;
   logic [27:0] c_load = '0, d_load = '0;
   logic [47:0] round_key;
   logic [4:0]  round_num;
   logic        done;
   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   des_key_sched dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .enc_mode(enc_mode),
      .c_load(c_load), .d_load(d_load), .adv(adv),
      .round_key(round_key), .round_num(round_num), .done(done)
   );

   localparam int SEL [48] = '{
      14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
      23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
      41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
      44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
   };

   function automatic int shifts(input int r);
      return (r == 1 || r == 2 || r == 9 || r == 16) ? 1 : 2;
   endfunction

   function automatic logic [27:0] rotl(input logic [27:0] v, input int n);
      logic [27:0] t = v;
      for (int i = 0; i < n % 28; i++) t = {t[26:0], t[27]};
      return t;
   endfunction

   // expected key for round r: total left rotation of the encrypt round it maps to
   function automatic logic [47:0] exp_key(input logic [27:0] c, input logic [27:0] d,
                                           input bit enc, input int r);
      int er = enc ? r : 17 - r;
      int cum = 0;
      logic [55:0] cd;
      logic [47:0] k;
      for (int i = 1; i <= er; i++) cum += shifts(i);
      cd = {rotl(c, cum), rotl(d, cum)};
      for (int i = 0; i < 48; i++) k[47-i] = cd[56 - SEL[i]];
      return k;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_start(input bit enc, input logic [27:0] c, input logic [27:0] d,
                           input bit with_adv);
      start = 1'b1; enc_mode = enc; c_load = c; d_load = d; adv = with_adv;
      tick();
      start = 1'b0; adv = 1'b0;
   endtask

   task automatic full_run(input bit enc, input logic [27:0] c, input logic [27:0] d);
      do_start(enc, c, d, 1'b0);
      chk(enc ? "R2 round" : "R3 round", 64'(round_num), 64'd1);
      chk(enc ? "R2 key" : "R3 key", 64'(round_key), 64'(exp_key(c, d, enc, 1)));
      for (int r = 2; r <= 16; r++) begin
         int gap = int'($urandom_range(0, 2));
         for (int g = 0; g < gap; g++) begin
            enc_mode = ~enc_mode;
            tick();
         end
         if (gap > 0) begin
            chk("R10 key held", 64'(round_key), 64'(exp_key(c, d, enc, r - 1)));
            chk("R10 round held", 64'(round_num), 64'(r - 1));
         end
         adv = 1'b1;
         tick();
         adv = 1'b0;
         chk(enc ? "R4 round" : "R5 round", 64'(round_num), 64'(r));
         chk(enc ? "R4 key" : "R5 key", 64'(round_key), 64'(exp_key(c, d, enc, r)));
      end
      chk("R7 not done at 16", 64'(done), 64'd0);
      adv = 1'b1;
      tick();
      chk("R7 done", 64'(done), 64'd1);
      chk("R7 round", 64'(round_num), 64'd16);
      chk("R7 key", 64'(round_key), 64'(exp_key(c, d, enc, 16)));
      tick();
      adv = 1'b0;
      chk("R7 extra adv", 64'({done, round_num}), 64'({1'b1, 5'd16}));
      chk("R7 extra adv key", 64'(round_key), 64'(exp_key(c, d, enc, 16)));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [27:0] c, d;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1 reset round", 64'(round_num), 64'd0);
      chk("R1 reset done", 64'(done), 64'd0);
      rst_n = 1'b1;
      tick();
      chk("R1 after release key", 64'(round_key), 64'd0);
      // R8: strobe before start
      adv = 1'b1;
      tick(); tick();
      adv = 1'b0;
      chk("R8 idle adv round", 64'(round_num), 64'd0);
      chk("R8 idle adv done", 64'(done), 64'd0);
      // R6: half separation with directed halves
      do_start(1'b0, 28'hFFFFFFF, 28'h0, 1'b0);
      chk("R6 C to upper", 64'(round_key), 64'h0000_FFFFFF_000000);
      do_start(1'b0, 28'h0, 28'hFFFFFFF, 1'b0);
      chk("R6 D to lower", 64'(round_key), 64'h0000_000000_FFFFFF);
      do_start(1'b0, 28'h8000000, 28'h0, 1'b0);
      chk("R6 bit C27", 64'(round_key), 64'(exp_key(28'h8000000, 28'h0, 1'b0, 1)));
      // directed then random runs
      full_run(1'b1, 28'h0000001, 28'h8000000);
      full_run(1'b0, 28'h0000001, 28'h8000000);
      for (int t = 0; t < 8; t++) begin
         c = 28'($urandom);
         d = 28'($urandom);
         full_run(t[0], c, d);
      end
      // R9: start with strobe while done
      c = 28'($urandom); d = 28'($urandom);
      do_start(1'b1, c, d, 1'b1);
      chk("R9 start+adv after done round", 64'({done, round_num}), 64'({1'b0, 5'd1}));
      chk("R9 start+adv after done key", 64'(round_key), 64'(exp_key(c, d, 1'b1, 1)));
      for (int i = 0; i < 5; i++) begin
         adv = 1'b1;
         tick();
      end
      adv = 1'b0;
      chk("R9 mid run round", 64'(round_num), 64'd6);
      c = 28'($urandom); d = 28'($urandom);
      do_start(1'b0, c, d, 1'b1);
      chk("R9 restart round", 64'(round_num), 64'd1);
      chk("R9 restart key", 64'(round_key), 64'(exp_key(c, d, 1'b0, 1)));
      adv = 1'b1;
      tick();
      adv = 1'b0;
      chk("R9 restart follows new mode", 64'(round_key), 64'(exp_key(c, d, 1'b0, 2)));
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule